// File: doc/BRIEF.md
# DMA Channel Programming Port

This block is the host-facing programming port of an eight-channel DMA controller. Software reaches it through two byte-wide I/O locations. A byte written to the function location names one operation and one channel. The bytes of that operation's operand then move through the execute location, one byte per access. An internal byte pointer decides which byte of which register each access reaches. The block holds, for every channel, a 24-bit memory address, a 16-bit count, a 16-bit I/O port number, a mode byte and a mask bit. It presents all of them as flat configuration buses to a separate transfer engine.

A byte sequencer runs the operand streaming. It has three states. `ST_IDLE` accepts no execute bytes. `ST_LOAD` takes execute writes. `ST_FETCH` answers execute reads. Every function write resets the pointer, latches the operation, the channel and the operand length, and makes one transition. **IDLE/LOAD/FETCH -> LOAD** happens on a set-address, set-count, set-port, set-mode or set-arbitration code. **-> FETCH** happens on a get-address, get-count or get-status code. **-> IDLE** happens on a mask, unmask or master-clear code, or on any unassigned code. Inside LOAD, each execute write moves the pointer up by one. The write that carries the last operand byte is the **LOAD -> IDLE** transition. FETCH behaves the same way for execute reads, and the last read is the **FETCH -> IDLE** transition.

Top module: `dma_fn_port`

## Requirements
- R1: The function location is I/O offset 0x18 and the execute location is offset 0x1A. An access to any other offset has no effect on any register or output.
- R2: In a function write, bits [7:4] are the operation code and bits [2:0] are the channel number. Bit 3 is ignored. The write restarts the byte pointer at 0, so a sequence that was cut short is abandoned and the next operand starts at its first byte.
- R3: Code 0x2 loads the channel's 24-bit address from three execute writes, least significant byte first. Code 0x3 returns the same three bytes in the same order on execute reads.
- R4: Code 0x4 loads the channel's 16-bit count from two execute writes, low byte first. Code 0x5 reads the count back in that order.
- R5: Code 0x0 loads the channel's 16-bit I/O port number from two execute writes, low byte first.
- R6: Code 0x7 stores one execute byte as the channel's mode, unchanged. In that byte, bit 0 selects an I/O-port target, bit 2 enables a transfer that reads memory, bit 3 selects the write direction, and bit 6 selects 16-bit transfers.
- R7: Code 0x9 sets the channel's mask bit and code 0xA clears it. Either one takes effect in the cycle after the function write and needs no execute bytes.
- R8: Code 0xD (master clear) sets every mask bit and clears every mode byte. Addresses, counts and port numbers keep their values.
- R9: After reset every mask bit is 1, every address, count, port and mode is 0, and an execute read returns 0.
- R10: An execute write made when no load operand byte is pending is ignored. This covers writes past the operand length, writes during a get operation, and writes in idle. An execute read made when no fetch byte is pending returns 0 and changes nothing.
- R11: Code 0x6 returns one byte whose bit n is channel n's mask bit. Code 0x8 takes one execute byte and discards it. Codes 0x1, 0xB, 0xC, 0xE and 0xF move the sequencer to idle and change nothing else.
- R12: The configuration outputs change only in the cycle after an accepted write. A read never changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O offset of the access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, valid in the cycle io_rd is high |
| ch_addr | output | NCH*24 | Per-channel address, channel n at bits [24n+23:24n] |
| ch_count | output | NCH*16 | Per-channel count |
| ch_port | output | NCH*16 | Per-channel I/O port number |
| ch_mode | output | NCH*8 | Per-channel mode byte |
| ch_mask | output | NCH | Per-channel mask, 1 = disabled |

## Verification
The bench uses the default build: eight channels and an 8-bit offset bus. With eight channels, channel 7 is the last one. A function byte with bit 3 set therefore shows that the channel field is exactly three bits wide. The status byte fills all eight of its bits. With the 8-bit offset bus, the bench can probe 0x19, the offset that lies between the two real locations. Random sequences of operations, with random channels and operand values, run alongside directed cases. The directed cases cover an interrupted sequence, wrong-direction accesses and master clear.

// File: rtl/dma_fn_pkg.sv
package dma_fn_pkg;
    localparam int AW = 24;
    localparam int CW = 16;
    localparam int PW = 16;
    localparam int MW = 8;

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_FETCH} seq_state_t;
    typedef enum logic [1:0] {K_NONE, K_LOAD, K_FETCH} op_kind_t;

    typedef struct packed {
        op_kind_t   kind;
        logic [1:0] len;
    } op_info_t;

    localparam logic [3:0] OP_SET_PORT = 4'h0;
    localparam logic [3:0] OP_SET_ADDR = 4'h2;
    localparam logic [3:0] OP_GET_ADDR = 4'h3;
    localparam logic [3:0] OP_SET_CNT  = 4'h4;
    localparam logic [3:0] OP_GET_CNT  = 4'h5;
    localparam logic [3:0] OP_GET_STAT = 4'h6;
    localparam logic [3:0] OP_SET_MODE = 4'h7;
    localparam logic [3:0] OP_SET_ARB  = 4'h8;
    localparam logic [3:0] OP_MASK     = 4'h9;
    localparam logic [3:0] OP_UNMASK   = 4'hA;
    localparam logic [3:0] OP_CLEAR    = 4'hD;
endpackage

// File: rtl/dma_fn_decode.sv
module dma_fn_decode
    import dma_fn_pkg::*;
(
    input  logic [3:0] op,
    output op_info_t   info
);
    always_comb begin
        info = '{kind: K_NONE, len: 2'd0};
        unique case (op)
            OP_SET_PORT: info = '{kind: K_LOAD,  len: 2'd2};
            OP_SET_ADDR: info = '{kind: K_LOAD,  len: 2'd3};
            OP_GET_ADDR: info = '{kind: K_FETCH, len: 2'd3};
            OP_SET_CNT:  info = '{kind: K_LOAD,  len: 2'd2};
            OP_GET_CNT:  info = '{kind: K_FETCH, len: 2'd2};
            OP_GET_STAT: info = '{kind: K_FETCH, len: 2'd1};
            OP_SET_MODE: info = '{kind: K_LOAD,  len: 2'd1};
            OP_SET_ARB:  info = '{kind: K_LOAD,  len: 2'd1};
            default:     info = '{kind: K_NONE,  len: 2'd0};
        endcase
    end
endmodule

// File: rtl/dma_fn_seq.sv
module dma_fn_seq
    import dma_fn_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fn_we,
    input  logic [3:0]      fn_op,
    input  logic [CH_W-1:0] fn_ch,
    input  logic            exe_we,
    input  logic            exe_re,
    output seq_state_t      st,
    output logic [3:0]      cur_op,
    output logic [CH_W-1:0] cur_ch,
    output logic [1:0]      ptr,
    output logic            load_hit,
    output logic            fetch_hit
);
    op_info_t        info;
    seq_state_t      st_n;
    logic [3:0]      op_n;
    logic [CH_W-1:0] ch_n;
    logic [1:0]      ptr_n, len_q, len_n;

    dma_fn_decode u_dec (.op(fn_op), .info(info));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cur_op <= '0;
            cur_ch <= '0;
            ptr    <= '0;
            len_q  <= '0;
        end else begin
            st     <= st_n;
            cur_op <= op_n;
            cur_ch <= ch_n;
            ptr    <= ptr_n;
            len_q  <= len_n;
        end
    end

    // next state
    always_comb begin
        st_n  = st;
        op_n  = cur_op;
        ch_n  = cur_ch;
        ptr_n = ptr;
        len_n = len_q;
        if (fn_we) begin
            op_n  = fn_op;
            ch_n  = fn_ch;
            ptr_n = 2'd0;
            len_n = info.len;
            unique case (info.kind)
                K_LOAD:  st_n = ST_LOAD;
                K_FETCH: st_n = ST_FETCH;
                default: st_n = ST_IDLE;
            endcase
        end else begin
            unique case (st)
                ST_LOAD: if (exe_we) begin
                    if (ptr == len_q - 2'd1) begin
                        st_n  = ST_IDLE;
                        ptr_n = 2'd0;
                    end else begin
                        ptr_n = ptr + 2'd1;
                    end
                end
                ST_FETCH: if (exe_re) begin
                    if (ptr == len_q - 2'd1) begin
                        st_n  = ST_IDLE;
                        ptr_n = 2'd0;
                    end else begin
                        ptr_n = ptr + 2'd1;
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        load_hit  = 1'b0;
        fetch_hit = 1'b0;
        unique case (st)
            ST_LOAD:  load_hit  = exe_we;
            ST_FETCH: fetch_hit = exe_re;
            default: ;
        endcase
    end
endmodule

// File: rtl/dma_fn_regs.sv
module dma_fn_regs
    import dma_fn_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fn_we,
    input  logic [3:0]       fn_op,
    input  logic [CH_W-1:0]  fn_ch,
    input  logic             load_hit,
    input  logic [3:0]       cur_op,
    input  logic [CH_W-1:0]  cur_ch,
    input  logic [1:0]       ptr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rd_byte,
    output logic [NCH*AW-1:0] ch_addr,
    output logic [NCH*CW-1:0] ch_count,
    output logic [NCH*PW-1:0] ch_port,
    output logic [NCH*MW-1:0] ch_mode,
    output logic [NCH-1:0]    ch_mask
);
    logic [AW-1:0] addr_r  [NCH];
    logic [CW-1:0] count_r [NCH];
    logic [PW-1:0] port_r  [NCH];
    logic [MW-1:0] mode_r  [NCH];
    logic [NCH-1:0] mask_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                addr_r[c]  <= '0;
                count_r[c] <= '0;
                port_r[c]  <= '0;
                mode_r[c]  <= '0;
            end
            mask_r <= '1;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (fn_we) begin
                    if (fn_op == OP_CLEAR) begin
                        mask_r[c] <= 1'b1;
                        mode_r[c] <= '0;
                    end else if (fn_op == OP_MASK && fn_ch == CH_W'(c)) begin
                        mask_r[c] <= 1'b1;
                    end else if (fn_op == OP_UNMASK && fn_ch == CH_W'(c)) begin
                        mask_r[c] <= 1'b0;
                    end
                end
                if (load_hit && cur_ch == CH_W'(c)) begin
                    case (cur_op)
                        OP_SET_ADDR: addr_r[c][{ptr, 3'b000} +: 8]     <= wdata;
                        OP_SET_CNT:  count_r[c][{ptr[0], 3'b000} +: 8] <= wdata;
                        OP_SET_PORT: port_r[c][{ptr[0], 3'b000} +: 8]  <= wdata;
                        OP_SET_MODE: mode_r[c] <= wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        rd_byte = 8'h00;
        case (cur_op)
            OP_GET_ADDR: rd_byte = addr_r[cur_ch][{ptr, 3'b000} +: 8];
            OP_GET_CNT:  rd_byte = count_r[cur_ch][{ptr[0], 3'b000} +: 8];
            OP_GET_STAT: rd_byte = 8'(mask_r);
            default: ;
        endcase
    end

    for (genvar g = 0; g < NCH; g++) begin : g_flat
        assign ch_addr[g*AW +: AW]  = addr_r[g];
        assign ch_count[g*CW +: CW] = count_r[g];
        assign ch_port[g*PW +: PW]  = port_r[g];
        assign ch_mode[g*MW +: MW]  = mode_r[g];
    end
    assign ch_mask = mask_r;
endmodule

// File: rtl/dma_fn_port.sv
module dma_fn_port
    import dma_fn_pkg::*;
#(
    parameter int              NCH     = 8,
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] FN_OFS  = ADDR_W'(8'h18),
    parameter logic [ADDR_W-1:0] EXE_OFS = ADDR_W'(8'h1A)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    output logic [NCH*AW-1:0]   ch_addr,
    output logic [NCH*CW-1:0]   ch_count,
    output logic [NCH*PW-1:0]   ch_port,
    output logic [NCH*MW-1:0]   ch_mode,
    output logic [NCH-1:0]      ch_mask
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic            fn_we, exe_we, exe_re, load_hit, fetch_hit;
    seq_state_t      st;
    logic [3:0]      cur_op;
    logic [CH_W-1:0] cur_ch;
    logic [1:0]      ptr;
    logic [7:0]      rd_byte;

    assign fn_we  = io_wr && (io_addr == FN_OFS);
    assign exe_we = io_wr && (io_addr == EXE_OFS);
    assign exe_re = io_rd && (io_addr == EXE_OFS);

    dma_fn_seq #(.CH_W(CH_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .fn_we(fn_we), .fn_op(io_wdata[7:4]),
        .fn_ch(io_wdata[CH_W-1:0]), .exe_we(exe_we), .exe_re(exe_re),
        .st(st), .cur_op(cur_op), .cur_ch(cur_ch), .ptr(ptr),
        .load_hit(load_hit), .fetch_hit(fetch_hit)
    );

    dma_fn_regs #(.NCH(NCH), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .fn_we(fn_we), .fn_op(io_wdata[7:4]),
        .fn_ch(io_wdata[CH_W-1:0]), .load_hit(load_hit), .cur_op(cur_op),
        .cur_ch(cur_ch), .ptr(ptr), .wdata(io_wdata), .rd_byte(rd_byte),
        .ch_addr(ch_addr), .ch_count(ch_count), .ch_port(ch_port),
        .ch_mode(ch_mode), .ch_mask(ch_mask)
    );

    assign io_rdata = fetch_hit ? rd_byte : 8'h00;
endmodule

// File: rtl/dma_fn_chk.sv
module dma_fn_chk
    import dma_fn_pkg::*;
#(
    parameter int                NCH     = 8,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] FN_OFS  = ADDR_W'(8'h18),
    parameter logic [ADDR_W-1:0] EXE_OFS = ADDR_W'(8'h1A)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  io_addr,
    input logic               io_wr,
    input logic               io_rd,
    input logic [7:0]         io_wdata,
    input logic [7:0]         io_rdata,
    input logic [NCH*AW-1:0]  ch_addr,
    input logic [NCH*CW-1:0]  ch_count,
    input logic [NCH*PW-1:0]  ch_port,
    input logic [NCH*MW-1:0]  ch_mode,
    input logic [NCH-1:0]     ch_mask,
    input seq_state_t         st,
    input logic [1:0]         ptr
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    // R2
    ptr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == FN_OFS) |=> (ptr == 2'd0));

    // R2
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr != 2'd3);

    // R7
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == FN_OFS && io_wdata[7:4] == OP_MASK)
        |=> ch_mask[$past(io_wdata[CH_W-1:0])]);

    // R7
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == FN_OFS && io_wdata[7:4] == OP_UNMASK)
        |=> !ch_mask[$past(io_wdata[CH_W-1:0])]);

    // R8
    master_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == FN_OFS && io_wdata[7:4] == OP_CLEAR)
        |=> ((&ch_mask) && (ch_mode == '0)));

    // R10
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && st != ST_FETCH) |-> (io_rdata == 8'h00));

    // R12
    outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> ($stable(ch_addr) && $stable(ch_count) && $stable(ch_port)
                    && $stable(ch_mode) && $stable(ch_mask)));
endmodule

bind dma_fn_port dma_fn_chk #(
    .NCH(NCH), .ADDR_W(ADDR_W), .FN_OFS(FN_OFS), .EXE_OFS(EXE_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .ch_addr(ch_addr),
    .ch_count(ch_count), .ch_port(ch_port), .ch_mode(ch_mode),
    .ch_mask(ch_mask), .st(st), .ptr(ptr)
);

// File: tb/dma_fn_port_test.sv
module dma_fn_port_test;
    localparam int NCH = 8;
    localparam logic [7:0] FN  = 8'h18;
    localparam logic [7:0] EXE = 8'h1A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] io_addr = '0;
    logic io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic [NCH*24-1:0] ch_addr;
    logic [NCH*16-1:0] ch_count, ch_port;
    logic [NCH*8-1:0]  ch_mode;
    logic [NCH-1:0]    ch_mask;

    int checks = 0, failures = 0;

    logic [23:0] m_addr  [NCH];
    logic [15:0] m_count [NCH];
    logic [15:0] m_port  [NCH];
    logic [7:0]  m_mode  [NCH];
    logic [NCH-1:0] m_mask;

    always #4 clk = ~clk;

    dma_fn_port uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .ch_addr(ch_addr),
        .ch_count(ch_count), .ch_port(ch_port), .ch_mode(ch_mode), .ch_mask(ch_mask)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] v);
        io_addr = a; io_rd = 1'b1;
        #1 v = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    function automatic logic [7:0] fn_byte(logic [3:0] op, int ch);
        return {op, 4'(ch)};
    endfunction

    function automatic logic [7:0] byte_of(logic [23:0] v, int i);
        return v[i*8 +: 8];
    endfunction

    task automatic cmp_all(string tag);
        for (int c = 0; c < NCH; c++) begin
            chk(tag, 32'(ch_addr[c*24 +: 24]),  32'(m_addr[c]));
            chk(tag, 32'(ch_count[c*16 +: 16]), 32'(m_count[c]));
            chk(tag, 32'(ch_port[c*16 +: 16]),  32'(m_port[c]));
            chk(tag, 32'(ch_mode[c*8 +: 8]),    32'(m_mode[c]));
        end
        chk(tag, 32'(ch_mask), 32'(m_mask));
    endtask

    task automatic set_addr(int c, logic [23:0] v);
        wr(FN, fn_byte(4'h2, c));
        for (int i = 0; i < 3; i++) wr(EXE, byte_of(v, i));
        m_addr[c] = v;
    endtask

    task automatic set_count(int c, logic [15:0] v);
        wr(FN, fn_byte(4'h4, c));
        wr(EXE, v[7:0]); wr(EXE, v[15:8]);
        m_count[c] = v;
    endtask

    task automatic set_port(int c, logic [15:0] v);
        wr(FN, fn_byte(4'h0, c));
        wr(EXE, v[7:0]); wr(EXE, v[15:8]);
        m_port[c] = v;
    endtask

    task automatic set_mode(int c, logic [7:0] v);
        wr(FN, fn_byte(4'h7, c));
        wr(EXE, v);
        m_mode[c] = v;
    endtask

    task automatic get_addr(int c, string tag);
        logic [7:0] v;
        wr(FN, fn_byte(4'h3, c));
        for (int i = 0; i < 3; i++) begin
            rd(EXE, v);
            chk(tag, 32'(v), 32'(byte_of(m_addr[c], i)));
        end
    endtask

    task automatic get_count(int c, string tag);
        logic [7:0] v;
        wr(FN, fn_byte(4'h5, c));
        rd(EXE, v); chk(tag, 32'(v), 32'(m_count[c][7:0]));
        rd(EXE, v); chk(tag, 32'(v), 32'(m_count[c][15:8]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        for (int c = 0; c < NCH; c++) begin
            m_addr[c] = '0; m_count[c] = '0; m_port[c] = '0; m_mode[c] = '0;
        end
        m_mask = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        cmp_all("R9");
        rd(EXE, v); chk("R9 read after reset", 32'(v), 0);

        // R3 address load and readback, last channel
        set_addr(7, 24'hABCDEF);
        cmp_all("R3");
        get_addr(7, "R3");
        // R10 read past operand length
        rd(EXE, v); chk("R10 extra read", 32'(v), 0);

        // R4 count, then R10 excess write ignored
        set_count(3, 16'h1234);
        wr(EXE, 8'h55);
        cmp_all("R4 R10");
        get_count(3, "R4");

        // R5 port, R6 mode
        set_port(0, 16'hBEEF);
        set_mode(5, 8'h4D);
        cmp_all("R5 R6");

        // R7 unmask, then R11 status byte
        wr(FN, fn_byte(4'hA, 5)); m_mask[5] = 1'b0;
        chk("R7 unmask", 32'(ch_mask), 32'(m_mask));
        wr(FN, 8'h60);
        rd(EXE, v); chk("R11 status", 32'(v), 32'(m_mask));

        // R11 arbitration byte discarded, unassigned code
        wr(FN, 8'h81); wr(EXE, 8'hFF);
        wr(FN, 8'hB3); wr(EXE, 8'h77);
        cmp_all("R11");

        // R1 write to 0x19 ignored
        wr(8'h19, 8'h95);
        wr(8'h1B, 8'h12);
        cmp_all("R1");

        // R2 channel bit 3 ignored: 0x9D masks channel 5
        wr(FN, 8'h9D); m_mask[5] = 1'b1;
        chk("R2 channel field", 32'(ch_mask), 32'(m_mask));

        // R2 interrupted sequence: one address byte, then count starts fresh
        wr(FN, fn_byte(4'h2, 1)); wr(EXE, 8'h11);
        m_addr[1][7:0] = 8'h11;
        set_count(1, 16'hA55A);
        cmp_all("R2 restart");

        // R10 write during a get is ignored
        wr(FN, fn_byte(4'h3, 7)); wr(EXE, 8'h00);
        cmp_all("R10 write in fetch");
        rd(EXE, v); chk("R10 fetch after stray write", 32'(v), 32'(m_addr[7][7:0]));

        // R8 master clear
        wr(FN, fn_byte(4'hA, 2)); m_mask[2] = 1'b0;
        wr(FN, 8'hD0);
        m_mask = '1;
        for (int c = 0; c < NCH; c++) m_mode[c] = '0;
        cmp_all("R8");

        // random mix
        for (int it = 0; it < 300; it++) begin
            int c, k;
            c = $urandom_range(0, NCH - 1);
            k = $urandom_range(0, 9);
            case (k)
                0: set_addr(c, 24'($urandom));
                1: set_count(c, 16'($urandom));
                2: set_port(c, 16'($urandom));
                3: set_mode(c, 8'($urandom));
                4: begin wr(FN, fn_byte(4'h9, c)); m_mask[c] = 1'b1; end
                5: begin wr(FN, fn_byte(4'hA, c)); m_mask[c] = 1'b0; end
                6: get_addr(c, "R3 random");
                7: get_count(c, "R4 random");
                8: begin wr(FN, 8'h60); rd(EXE, v); chk("R11 random", 32'(v), 32'(m_mask)); end
                default: begin
                    if ($urandom_range(0, 7) == 0) begin
                        wr(FN, 8'hD0);
                        m_mask = '1;
                        for (int j = 0; j < NCH; j++) m_mode[j] = '0;
                    end else begin
                        get_count(c, "R4 random");
                    end
                end
            endcase
            cmp_all("R12");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule